// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block is a single-clock synchronous memory whose data phase always trails its command by exactly one cycle. A command (address, read/write select, load/advance select, chip selects) is captured on a rising edge. The matching read data is then presented during the following cycle, straight from the array with no output register. For a write, the data is taken at the edge that closes that cycle. Because every command has the same one-cycle offset, reads and writes can alternate on consecutive cycles with no idle slot on the data bus.

Words are 36 bits wide, made of four 9-bit byte lanes, each of which can be masked on a write. A load samples a fresh external address. An advance instead steps an internal 4-beat burst counter and repeats the operation type of the last load. The burst order is linear or interleaved, chosen by a mode pin. A clock enable freezes the whole block. Three chip selects (two active low, one active high) gate new commands. An asynchronous output enable can switch off the drive at any moment.

Top module: `zbt_burst_ram`

## Requirements
- R1: A load with `is_read`=1 and all selects active, captured at edge N, drives `dout_en`=1 and `dout` = the stored word at that address throughout the cycle after edge N (provided `oe_n`=0).
- R2: A load with `is_read`=0 and all selects active, captured at edge N, writes `din` at edge N+1. A read loaded at edge N+1 to the same address returns that new word, so write/read alternate with no idle cycle.
- R3: During a write data phase, `lane_wr_n[i]`=0 stores `din[9i+8:9i]`, and `lane_wr_n[i]`=1 leaves bits 9i+8:9i of the stored word unchanged.
- R4: At an edge with `clk_en`=0, every other synchronous input is ignored. The pending data phase (including a pending write, whose data is then taken at the next enabled edge) and the burst counter hold.
- R5: A load (`burst_next`=0) with any select inactive starts nothing and leaves `dout_en`=0 in the following cycle. A write or read already pending from the previous command still completes its data phase.
- R6: With `order_sel`=0 (linear), advance k (k=1,2,3,4,...) after a load of address A accesses A with its low two bits replaced by (A[1:0]+k) mod 4. The operation type is the one from the load.
- R7: With `order_sel`=1 (interleaved), advance k accesses A with its low two bits replaced by A[1:0] XOR (k mod 4).
- R8: An advance (`burst_next`=1) issued after reset before any load, or after a deselecting load, writes nothing and leaves `dout_en`=0.
- R9: `dout_en` is 0 in the cycle after a write load. `oe_n`=1 forces `dout_en`=0 and `dout`=0 at once, without waiting for a clock edge.
- R10: While `rst_n`=0, and after reset until the first load, `dout_en`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable, 1 = edges take effect |
| burst_next | input | 1 | 0 = load new address and operation, 1 = advance burst |
| is_read | input | 1 | Operation on load: 1 = read, 0 = write |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| addr | input | AW (log2 DEPTH, 6 by default) | Word address on load |
| lane_wr_n | input | 4 | Per-lane write mask, active low, sampled with write data |
| order_sel | input | 1 | Burst order: 0 = linear, 1 = interleaved (held static while a burst runs) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, 0 when not driven |
| dout_en | output | 1 | Read data is being driven |

## Verification
The hardest state to reach is a clock-enable stall that lands inside a data phase. This happens with a pending write whose data must not be taken until the enable returns, and with a read burst whose counter must not step. The stimulus reaches it by dropping `clk_en` directly after a write load and in the middle of a linear read burst. During those stalled cycles it drives conflicting loads, selects and write data, then checks that the pending word and burst address come out unchanged once the enable returns. Advances issued after a deselect and straight after reset are also driven with live write data, so that a stray write would show up when the same addresses are read back.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int unsigned LANES     = 4;
  localparam int unsigned LANE_W    = 9;
  localparam int unsigned WORD_W    = LANES * LANE_W;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned BEAT_W    = $clog2(BURST_LEN);

  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} op_e;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVED = 1'b1} order_e;
endpackage

// File: rtl/zbt_cmd_ctrl.sv
module zbt_cmd_ctrl
  import zbt_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              burst_next,
  input  logic              sel_ok,
  input  logic              is_read,
  input  logic [AW-1:0]     addr,
  output logic              pend_valid,
  output op_e               pend_op,
  output logic [AW-1:0]     base,
  output logic [BEAT_W-1:0] beat
);
  logic [AW-1:0]     base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  op_e               op_q, op_d;
  logic              act_q, act_d;
  logic              pend_q, pend_d;

  // next-state: load, deselect or advance, all gated by the clock enable
  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    op_d   = op_q;
    act_d  = act_q;
    pend_d = pend_q;
    if (clk_en) begin
      if (!burst_next) begin
        if (sel_ok) begin
          base_d = addr;
          beat_d = '0;
          op_d   = op_e'(is_read);
          act_d  = 1'b1;
          pend_d = 1'b1;
        end else begin
          act_d  = 1'b0;
          pend_d = 1'b0;
        end
      end else if (act_q) begin
        beat_d = beat_q + 1'b1;
        pend_d = 1'b1;
      end else begin
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      op_q   <= OP_READ;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
      op_q   <= op_d;
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  assign pend_valid = pend_q;
  assign pend_op    = op_q;
  assign base       = base_q;
  assign beat       = beat_q;

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(base_q) && $stable(beat_q) && $stable(pend_q) && $stable(op_q)));

  // R6
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && burst_next && act_q) |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));

  // R8
  idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && burst_next && !act_q) |=> !pend_q);
endmodule

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
  import zbt_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic [AW-1:0]     base,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [AW-1:0]     baddr
);
  logic [BEAT_W-1:0] low;

  always_comb begin
    if (order == ORD_INTERLEAVED) low = base[BEAT_W-1:0] ^ beat;
    else                          low = base[BEAT_W-1:0] + beat;
    baddr = {base[AW-1:BEAT_W], low};
  end
endmodule

// File: rtl/zbt_store.sv
module zbt_store
  import zbt_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     waddr,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && !lane_wr_n[g]) arr[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = arr[waddr];
  end
endmodule

// File: rtl/zbt_burst_ram.sv
module zbt_burst_ram
  import zbt_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              burst_next,
  input  logic              is_read,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              cs_c_n,
  input  logic [AW-1:0]     addr,
  input  logic [3:0]        lane_wr_n,
  input  logic              order_sel,
  input  logic              oe_n,
  input  logic [35:0]       din,
  output logic [35:0]       dout,
  output logic              dout_en
);
  logic              sel_ok;
  logic              pend_valid;
  op_e               pend_op;
  logic [AW-1:0]     base;
  logic [BEAT_W-1:0] beat;
  logic [AW-1:0]     cur_addr;
  logic [WORD_W-1:0] rdata;
  logic              wr_commit;
  logic              rd_phase;

  assign sel_ok = !cs_a_n && cs_b && !cs_c_n;

  zbt_cmd_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .burst_next (burst_next),
    .sel_ok     (sel_ok),
    .is_read    (is_read),
    .addr       (addr),
    .pend_valid (pend_valid),
    .pend_op    (pend_op),
    .base       (base),
    .beat       (beat)
  );

  zbt_burst_seq #(.AW(AW)) u_seq (
    .base  (base),
    .beat  (beat),
    .order (order_e'(order_sel)),
    .baddr (cur_addr)
  );

  assign wr_commit = clk_en && pend_valid && (pend_op == OP_WRITE);
  assign rd_phase  = pend_valid && (pend_op == OP_READ);

  zbt_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk       (clk),
    .wr_en     (wr_commit),
    .waddr     (cur_addr),
    .lane_wr_n (lane_wr_n),
    .wdata     (din),
    .rdata     (rdata)
  );

  // flow-through read: array output gated only by the async enable
  assign dout_en = rd_phase && !oe_n;
  assign dout    = dout_en ? rdata : '0;

  // R1
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !burst_next && sel_ok && is_read) |=> (dout_en || oe_n));

  // R9
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !burst_next && sel_ok && !is_read) |=> !dout_en);

  // R5
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !burst_next && !sel_ok) |=> !dout_en);
endmodule

// File: tb/sim_zbt_burst_ram.sv
module sim_zbt_burst_ram;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en, burst_next, is_read, cs_a_n, cs_b, cs_c_n;
  logic [AW-1:0] addr;
  logic [3:0]    lane_wr_n;
  logic          order_sel, oe_n;
  logic [35:0]   din, dout;
  logic          dout_en;

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  string cur    = "R10";

  // behavioural reference state
  logic [35:0] ref_mem [DEPTH];
  bit          m_pend = 0, m_prd = 0, m_act = 0, m_op = 0;
  int          m_base = 0, m_k = 0, m_paddr = 0;

  always #10 clk = ~clk;

  zbt_burst_ram #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .burst_next(burst_next),
    .is_read(is_read), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .addr(addr), .lane_wr_n(lane_wr_n), .order_sel(order_sel), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [35:0] pat(input int i);
    return {4{9'((i * 37 + 5) % 512)}} ^ 36'h5_A5A5_A5A5;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: one step per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_act = 0;
    end else if (clk_en) begin
      if (m_pend && !m_prd)
        for (int l = 0; l < 4; l++)
          if (!lane_wr_n[l]) ref_mem[m_paddr][l*9 +: 9] = din[l*9 +: 9];
      if (!burst_next) begin
        if (!cs_a_n && cs_b && !cs_c_n) begin
          m_act = 1; m_base = int'(addr); m_k = 0; m_op = is_read;
          m_pend = 1; m_prd = is_read; m_paddr = m_base;
        end else begin
          m_act = 0; m_pend = 0;
        end
      end else if (m_act) begin
        m_k = (m_k + 1) % 4;
        if (order_sel) m_paddr = (m_base & ~3) | ((m_base & 3) ^ m_k);
        else           m_paddr = (m_base & ~3) | (((m_base & 3) + m_k) % 4);
        m_pend = 1; m_prd = m_op;
      end else begin
        m_pend = 0;
      end
    end
  end

  // cycle compare against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic        e_en;
      logic [35:0] e_d;
      e_en = m_pend && m_prd && !oe_n;
      e_d  = e_en ? ref_mem[m_paddr] : 36'h0;
      check(cur, {dout_en, dout} === {e_en, e_d}, {dout_en, dout}, {e_en, e_d});
    end
  end

  task automatic op(input logic nx, input logic rd, input int a, input logic [3:0] lw,
                    input logic [35:0] d, input logic sel, input logic ce);
    @(negedge clk); #2;
    burst_next = nx; is_read = rd; addr = AW'(a); lane_wr_n = lw; din = d;
    cs_a_n = !sel; cs_b = sel; cs_c_n = !sel; clk_en = ce;
  endtask

  task automatic expect_rd(input string tag, input logic [35:0] v);
    #12;
    check(tag, dout_en === 1'b1 && dout === v, {dout_en, dout}, {1'b1, v});
  endtask

  task automatic expect_off(input string tag);
    #12;
    check(tag, dout_en === 1'b0 && dout === 36'h0, {dout_en, dout}, 37'h0);
  endtask

  initial begin
    logic [35:0] wa, wb, d0, d1, d2, d3;
    rst_n = 1'b0; clk_en = 1'b1; burst_next = 1'b0; is_read = 1'b1;
    cs_a_n = 1'b1; cs_b = 1'b0; cs_c_n = 1'b1; addr = '0; lane_wr_n = 4'hF;
    order_sel = 1'b0; oe_n = 1'b0; din = '0;

    // R10: reset holds the bus off
    repeat (3) @(negedge clk);
    check("R10", dout_en === 1'b0 && dout === 36'h0, {dout_en, dout}, 37'h0);
    #2 rst_n = 1'b1;

    // R8: advances before any load are no-ops
    cur = "R8";
    op(1, 0, 3, 4'h0, 36'hF_FFFF_FFFF, 1, 1); expect_off("R8");
    op(1, 1, 3, 4'h0, 36'hF_FFFF_FFFF, 1, 1); expect_off("R8");

    // R2: back-to-back writes fill the whole array
    cur = "R2";
    for (int i = 0; i < DEPTH; i++) op(0, 0, i, 4'h0, (i == 0) ? 36'h0 : pat(i - 1), 1, 1);
    op(0, 1, 0, 4'h0, pat(DEPTH - 1), 1, 1);
    // R1: back-to-back reads, data one cycle after the command
    cur = "R1";
    expect_rd("R1", pat(0));
    for (int i = 1; i < 8; i++) begin
      op(0, 1, i, 4'hF, 36'h0, 1, 1);
      expect_rd("R1", pat(i));
    end

    // R2: write then read same address, no gap; read then write
    cur = "R2";
    op(0, 0, 20, 4'h0, 36'h0, 1, 1);
    op(0, 1, 20, 4'h0, 36'h1_2345_6789, 1, 1); expect_rd("R2", 36'h1_2345_6789);
    op(0, 0, 21, 4'h0, 36'h0, 1, 1);
    op(0, 1, 21, 4'h0, 36'hC_0FFE_E123, 1, 1); expect_rd("R2", 36'hC_0FFE_E123);

    // R9: bus released the cycle after a write load
    cur = "R9";
    op(0, 0, 33, 4'h0, 36'h0, 1, 1); expect_off("R9");
    op(0, 0, 0, 4'h0, 36'h3_3333_3333, 0, 1);

    // R3: lane masks (bit i of lane_wr_n low writes bits 9i+8:9i)
    cur = "R3";
    wa = 36'hA_BCDE_F012; wb = 36'h5_1234_5678;
    op(0, 0, 30, 4'h0, 36'h0, 1, 1);
    op(0, 0, 30, 4'h0, wa, 1, 1);
    op(0, 1, 30, 4'b1010, wb, 1, 1);
    expect_rd("R3", {wa[35:27], wb[26:18], wa[17:9], wb[8:0]});
    op(0, 0, 30, 4'hF, 36'h0, 1, 1);
    op(0, 1, 30, 4'hF, 36'h0, 1, 1);
    expect_rd("R3", {wa[35:27], wb[26:18], wa[17:9], wb[8:0]});

    // R6: linear write burst from 41 -> 41,42,43,40
    cur = "R6";
    d0 = 36'h0_0000_0D00; d1 = 36'h1_1111_1D11; d2 = 36'h2_2222_2D22; d3 = 36'h3_3333_3D33;
    order_sel = 1'b0;
    op(0, 0, 41, 4'h0, 36'h0, 1, 1);
    op(1, 1, 0, 4'h0, d0, 0, 1);
    op(1, 1, 0, 4'h0, d1, 0, 1);
    op(1, 1, 0, 4'h0, d2, 0, 1);
    op(0, 1, 0, 4'h0, d3, 0, 1);

    // R7: interleaved read burst from 41 -> 41,40,43,42, then wrap to 41
    cur = "R7";
    op(0, 1, 0, 4'hF, 36'h0, 0, 1);
    #2 order_sel = 1'b1;
    op(0, 1, 41, 4'hF, 36'h0, 1, 1); expect_rd("R7", d0);
    op(1, 0, 0, 4'hF, 36'h0, 0, 1);  expect_rd("R7", d3);
    op(1, 0, 0, 4'hF, 36'h0, 0, 1);  expect_rd("R7", d2);
    op(1, 0, 0, 4'hF, 36'h0, 0, 1);  expect_rd("R7", d1);
    op(1, 0, 0, 4'hF, 36'h0, 0, 1);  expect_rd("R7", d0);
    op(0, 1, 0, 4'hF, 36'h0, 0, 1);
    #2 order_sel = 1'b0;

    // R6: linear read burst from 42 -> 42,43,40,41
    cur = "R6";
    op(0, 1, 42, 4'hF, 36'h0, 1, 1); expect_rd("R6", d1);
    op(1, 0, 0, 4'hF, 36'h0, 0, 1);  expect_rd("R6", d2);
    op(1, 0, 0, 4'hF, 36'h0, 0, 1);  expect_rd("R6", d3);
    op(1, 0, 0, 4'hF, 36'h0, 0, 1);  expect_rd("R6", d0);

    // R4: stall inside a read burst with conflicting inputs
    cur = "R4";
    op(0, 1, 42, 4'hF, 36'h0, 1, 1);            expect_rd("R4", d1);
    op(0, 0, 63, 4'h0, 36'hF_FFFF_FFFF, 1, 0);  expect_rd("R4", d1);
    op(0, 0, 5, 4'h0, 36'hE_EEEE_EEEE, 0, 0);   expect_rd("R4", d1);
    op(1, 0, 0, 4'hF, 36'h0, 0, 1);             expect_rd("R4", d2);
    // R4: stall with a pending write; data taken at next enabled edge
    op(0, 0, 12, 4'h0, 36'h0, 1, 1);
    op(0, 1, 12, 4'h0, 36'h9_9999_9999, 1, 0);
    op(0, 1, 0, 4'h0, 36'h7_7654_3210, 0, 1);
    op(0, 1, 12, 4'hF, 36'h0, 1, 1);            expect_rd("R4", 36'h7_7654_3210);
    op(0, 1, 63, 4'hF, 36'h0, 1, 1);            expect_rd("R4", pat(63));

    // R5: deselect still completes the pending write; R8 advances after it do nothing
    cur = "R5";
    op(0, 0, 50, 4'h0, 36'h0, 1, 1);
    op(0, 0, 50, 4'h0, 36'h5_0505_0505, 0, 1);  expect_off("R5");
    cur = "R8";
    op(1, 0, 51, 4'h0, 36'hB_AD0B_AD0B, 0, 1);  expect_off("R8");
    op(1, 0, 52, 4'h0, 36'hB_AD0B_AD0B, 1, 1);  expect_off("R8");
    op(0, 1, 50, 4'hF, 36'hB_AD0B_AD0B, 1, 1);  expect_rd("R5", 36'h5_0505_0505);
    op(0, 1, 51, 4'hF, 36'h0, 1, 1);            expect_rd("R8", pat(51));
    op(0, 1, 52, 4'hF, 36'h0, 1, 1);            expect_rd("R8", pat(52));
    // R5: deselect right after a read: read data phase still delivered
    op(0, 1, 7, 4'hF, 36'h0, 1, 1);
    op(0, 1, 8, 4'hF, 36'h0, 0, 1);             expect_off("R5");

    // R9: asynchronous output enable during a read data phase
    cur = "R9";
    op(0, 1, 5, 4'hF, 36'h0, 1, 1);
    #10 oe_n = 1'b1;
    #1 check("R9", dout_en === 1'b0 && dout === 36'h0, {dout_en, dout}, 37'h0);
    oe_n = 1'b0;
    #1 check("R9", dout_en === 1'b1 && dout === pat(5), {dout_en, dout}, {1'b1, pat(5)});
    op(0, 1, 0, 4'hF, 36'h0, 0, 1);
    op(0, 1, 0, 4'hF, 36'h0, 0, 1);

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule